// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Cell

This block is the interrupt priority cell of one peripheral on a daisy-chained interrupt line. A local request from the peripheral becomes pending. The cell then pulls the shared interrupt line low, but only while the priority input from upstream devices is high. When the processor runs an acknowledge cycle, the cell that still holds priority takes the acknowledge. That cell places its vector byte on the data bus and enters service. While the cell is busy, it blocks lower-priority devices by holding its priority output low.

The cell has no end-of-interrupt input. It snoops the processor's opcode fetches and watches for the two-byte return-from-interrupt sequence, which is a prefix byte followed by the return opcode in the next fetch. When a cell that is in service and has its priority input high sees that sequence, it leaves service and opens the chain again. A simple load port sets the vector byte.

Top module: `irq_chain_cell`

## Requirements
- R1: A rising edge of `irq_req_i` sets the pending state. Holding the request high does not set pending again after the cell has been acknowledged.
- R2: `int_no` is low only when the cell is pending, not in service, and `iei_i` is high. It follows `iei_i` combinationally.
- R3: Once pending, the cell keeps the request until it wins an acknowledge cycle. Losing an acknowledge or a temporary drop of `iei_i` does not clear it.
- R4: An acknowledge cycle is `m1_ni` and `iorq_ni` both low. The winner raises `vec_oe_o` in the same cycle that `iorq_ni` goes low and keeps it raised to the end of that cycle. Outside such a cycle `vec_oe_o` is low.
- R5: The cell wins only if it is pending and `iei_i` is high in the first cycle of the acknowledge. A cell that does not win drives no vector and does not enter service.
- R6: `ieo_o` equals `iei_i` while the cell is neither pending nor in service. Otherwise `ieo_o` is low.
- R7: An opcode fetch is `m1_ni` low, `rd_ni` low and `iorq_ni` high. The byte on `data_i` in the last sampled cycle of the fetch is the fetched byte. Memory reads with `m1_ni` high and acknowledge cycles do not affect the return detector.
- R8: A fetch of 0xED followed directly by a fetch of 0x4D releases the in-service state, provided `iei_i` is high when the second fetch completes.
- R9: After 0xED, a fetched byte other than 0x4D disarms the detector, unless that byte is 0xED again, in which case the detector stays armed. A fetch of 0x4D with no 0xED just before it has no effect.
- R10: A complete return sequence seen while `iei_i` is low leaves the in-service state unchanged.
- R11: A cycle with `vec_load_i` high stores `vec_data_i`. `vec_o` presents the stored byte. Reset clears it to 0x00.
- R12: After reset, `int_no` is high, `vec_oe_o` is low, and the cell is idle, so `ieo_o` follows `iei_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Local interrupt request from the peripheral |
| iei_i | input | 1 | Priority input from upstream devices, high = enabled |
| m1_ni | input | 1 | Processor opcode-fetch / acknowledge strobe, active low |
| iorq_ni | input | 1 | Processor I/O request strobe, active low |
| rd_ni | input | 1 | Processor read strobe, active low |
| data_i | input | 8 | Snooped processor data bus |
| vec_load_i | input | 1 | Load strobe for the vector byte |
| vec_data_i | input | 8 | Vector byte to load |
| int_no | output | 1 | Interrupt request, active low (release = high) |
| ieo_o | output | 1 | Priority output to downstream devices |
| vec_o | output | 8 | Vector byte for the data bus |
| vec_oe_o | output | 1 | Drive enable for `vec_o` during a won acknowledge |

## Verification
The assertions check several properties on every cycle. Pending is held until an acknowledge, and the cell enters service only after an acknowledge that starts with priority high. It leaves service only on a detected return sequence seen with priority high. The vector enable appears only inside an acknowledge cycle, priority passes through only when the cell is idle, and the detector arms only on a fetched prefix byte. The bench scenarios cover the behaviour that depends on a sequence. These are: the byte orders that must or must not release service, memory reads that fall between fetches, a held request level that must not re-arm pending, and the vector value placed on the bus.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam logic [7:0]  RET_PREFIX  = 8'hED;
  localparam logic [7:0]  RET_OPCODE  = 8'h4D;

  typedef enum logic [1:0] {
    CYC_NONE,
    CYC_FETCH,
    CYC_ACK,
    CYC_OTHER
  } cyc_kind_e;
endpackage

// File: rtl/irq_bus_snoop.sv
module irq_bus_snoop
  import irq_chain_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m1_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              fetch_end_o,
  output logic [DATA_W-1:0] fetch_byte_o,
  output logic              ack_now_o,
  output logic              ack_start_o
);
  cyc_kind_e         kind;
  logic              fetch_now;
  logic              fetch_q;
  logic              ack_q;
  logic [DATA_W-1:0] byte_q;

  always_comb begin
    if (!m1_ni && !iorq_ni)      kind = CYC_ACK;
    else if (!m1_ni && !rd_ni)   kind = CYC_FETCH;
    else if (!iorq_ni || !rd_ni) kind = CYC_OTHER;
    else                         kind = CYC_NONE;
  end

  assign fetch_now = (kind == CYC_FETCH);
  assign ack_now_o = (kind == CYC_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= 1'b0;
      ack_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      fetch_q <= fetch_now;
      ack_q   <= ack_now_o;
      if (fetch_now) byte_q <= data_i;
    end
  end

  // fetch is complete once strobes leave the fetch pattern
  assign fetch_end_o  = fetch_q && !fetch_now;
  assign fetch_byte_o = byte_q;
  assign ack_start_o  = ack_now_o && !ack_q;

  AST_ONE_CYCLE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_now, ack_now_o})); // R7
  AST_ACK_START_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_start_o |=> !ack_start_o); // R4
endmodule

// File: rtl/irq_ret_detect.sv
module irq_ret_detect
  import irq_chain_pkg::*;
#(
  parameter int unsigned       DATA_W = BYTE_W,
  parameter logic [DATA_W-1:0] PREFIX = RET_PREFIX,
  parameter logic [DATA_W-1:0] OPCODE = RET_OPCODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_end_i,
  input  logic [DATA_W-1:0] fetch_byte_i,
  output logic              ret_hit_o
);
  logic armed_q;
  logic is_prefix;
  logic is_opcode;

  assign is_prefix = (fetch_byte_i == PREFIX);
  assign is_opcode = (fetch_byte_i == OPCODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (fetch_end_i) armed_q <= is_prefix; // any other byte disarms
  end

  assign ret_hit_o = fetch_end_i && armed_q && is_opcode;

  AST_ARM_FROM_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(fetch_end_i && is_prefix)); // R8
  AST_DISARM_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_end_i && !is_prefix) |=> !armed_q); // R9
  AST_ARM_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_end_i |=> $stable(armed_q)); // R7
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic iei_i,
  input  logic ack_now_i,
  input  logic ack_start_i,
  input  logic ret_hit_i,
  output logic pending_o,
  output logic in_service_o,
  output logic drive_vec_o
);
  logic req_q;
  logic pending_q;
  logic in_service_q;
  logic owner_q;
  logic req_rise;
  logic win;
  logic release_svc;

  assign req_rise    = req_i && !req_q;
  assign win         = ack_start_i && pending_q && iei_i;
  assign release_svc = ret_hit_i && iei_i && in_service_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q        <= 1'b0;
      pending_q    <= 1'b0;
      in_service_q <= 1'b0;
      owner_q      <= 1'b0;
    end else begin
      req_q <= req_i;
      if (req_rise) pending_q <= 1'b1;
      else if (win) pending_q <= 1'b0;
      if (win)              in_service_q <= 1'b1;
      else if (release_svc) in_service_q <= 1'b0;
      if (!ack_now_i) owner_q <= 1'b0;
      else if (win)   owner_q <= 1'b1;
    end
  end

  // first acknowledge cycle decides combinationally so the vector is on time
  assign drive_vec_o  = ack_now_i && (owner_q || win);
  assign pending_o    = pending_q;
  assign in_service_o = in_service_q;

  AST_PENDING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !ack_start_i) |=> pending_q); // R3
  AST_SERVICE_FROM_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_service_q) |-> $past(ack_start_i && iei_i)); // R5
  AST_LOSER_STAYS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start_i && !iei_i && !in_service_q) |=> !in_service_q); // R5
  AST_RELEASE_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_service_q) |-> $past(ret_hit_i && iei_i)); // R10
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
  import irq_chain_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_o <= '0;
    else if (load_i) vec_o <= data_i;
  end

  AST_VEC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(vec_o)); // R11
endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell
  import irq_chain_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic              iei_i,
  input  logic              m1_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vec_load_i,
  input  logic [DATA_W-1:0] vec_data_i,
  output logic              int_no,
  output logic              ieo_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_oe_o
);
  logic              fetch_end;
  logic [DATA_W-1:0] fetch_byte;
  logic              ack_now;
  logic              ack_start;
  logic              ret_hit;
  logic              pending;
  logic              in_service;

  irq_bus_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk_i, .rst_ni, .m1_ni, .iorq_ni, .rd_ni, .data_i,
    .fetch_end_o(fetch_end), .fetch_byte_o(fetch_byte),
    .ack_now_o(ack_now), .ack_start_o(ack_start)
  );

  irq_ret_detect #(
    .DATA_W(DATA_W),
    .PREFIX(DATA_W'(RET_PREFIX)),
    .OPCODE(DATA_W'(RET_OPCODE))
  ) u_ret (
    .clk_i, .rst_ni,
    .fetch_end_i(fetch_end), .fetch_byte_i(fetch_byte),
    .ret_hit_o(ret_hit)
  );

  irq_prio_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .req_i(irq_req_i), .iei_i,
    .ack_now_i(ack_now), .ack_start_i(ack_start), .ret_hit_i(ret_hit),
    .pending_o(pending), .in_service_o(in_service), .drive_vec_o(vec_oe_o)
  );

  irq_vec_reg #(.DATA_W(DATA_W)) u_vec (
    .clk_i, .rst_ni, .load_i(vec_load_i), .data_i(vec_data_i), .vec_o
  );

  assign int_no = !(pending && !in_service && iei_i);
  assign ieo_o  = iei_i && !pending && !in_service;

  AST_VEC_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> (!m1_ni && !iorq_ni)); // R4
  AST_INT_NEEDS_IEI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> iei_i); // R2
  AST_IEO_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> !ieo_o); // R6
endmodule

// File: tb/tb_irq_chain_cell.sv
`timescale 1ns/1ps
module tb_irq_chain_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_req = 1'b0;
  logic       iei = 1'b1;
  logic       m1_n = 1'b1;
  logic       iorq_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic       vec_load = 1'b0;
  logic [7:0] vec_data = 8'h00;
  logic       int_n, ieo, vec_oe;
  logic [7:0] vec;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_chain_cell dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .iei_i(iei),
    .m1_ni(m1_n), .iorq_ni(iorq_n), .rd_ni(rd_n), .data_i(data),
    .vec_load_i(vec_load), .vec_data_i(vec_data),
    .int_no(int_n), .ieo_o(ieo), .vec_o(vec), .vec_oe_o(vec_oe)
  );

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] b);
    @(negedge clk); m1_n = 1'b0; rd_n = 1'b0; iorq_n = 1'b1; data = b;
    repeat (2) @(negedge clk);
    m1_n = 1'b1; rd_n = 1'b1; data = 8'h00;
    @(negedge clk);
  endtask

  task automatic memread(input logic [7:0] b);
    @(negedge clk); m1_n = 1'b1; rd_n = 1'b0; data = b;
    repeat (2) @(negedge clk);
    rd_n = 1'b1; data = 8'h00;
    @(negedge clk);
  endtask

  task automatic ack_cycle(input string rq, input logic exp_oe, input logic [7:0] exp_vec);
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0;
    #2;
    chk(rq, "vec_oe first ack cycle", {7'd0, vec_oe}, {7'd0, exp_oe});
    if (exp_oe) chk("R11", "vector value", vec, exp_vec);
    @(negedge clk);
    chk(rq, "vec_oe second ack cycle", {7'd0, vec_oe}, {7'd0, exp_oe});
    m1_n = 1'b1; iorq_n = 1'b1;
    #2;
    chk("R4", "vec_oe after ack", {7'd0, vec_oe}, 8'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "int_n after reset", {7'd0, int_n}, 8'd1);
    chk("R12", "vec_oe after reset", {7'd0, vec_oe}, 8'd0);
    chk("R12", "ieo after reset", {7'd0, ieo}, 8'd1);
    chk("R11", "vector reset value", vec, 8'h00);
    iei = 1'b0; #1;
    chk("R6", "idle ieo follows iei low", {7'd0, ieo}, 8'd0);
    iei = 1'b1;
  endtask

  task automatic t_load_vec;
    @(negedge clk); vec_load = 1'b1; vec_data = 8'h3C;
    @(negedge clk); vec_load = 1'b0; vec_data = 8'hFF;
    @(negedge clk);
    chk("R11", "loaded vector", vec, 8'h3C);
  endtask

  task automatic t_request;
    irq_req = 1'b1;
    @(negedge clk);
    chk("R1", "int_n after request edge", {7'd0, int_n}, 8'd0);
    chk("R6", "ieo low while pending", {7'd0, ieo}, 8'd0);
    iei = 1'b0; #1;
    chk("R2", "int_n released with iei low", {7'd0, int_n}, 8'd1);
    @(negedge clk); iei = 1'b1; #1;
    chk("R3", "int_n back after iei returns", {7'd0, int_n}, 8'd0);
  endtask

  task automatic t_ack_lose;
    iei = 1'b0;
    ack_cycle("R5", 1'b0, 8'h00);
    iei = 1'b1; #1;
    chk("R3", "still pending after lost ack", {7'd0, int_n}, 8'd0);
  endtask

  task automatic t_ack_win;
    ack_cycle("R4", 1'b1, 8'h3C);
    chk("R2", "no INT while in service", {7'd0, int_n}, 8'd1);
    chk("R6", "ieo low while in service", {7'd0, ieo}, 8'd0);
  endtask

  task automatic t_bad_sequences;
    fetch(8'h4D);
    chk("R9", "lone 0x4D keeps service", {7'd0, ieo}, 8'd0);
    fetch(8'hED); fetch(8'h00); fetch(8'h4D);
    chk("R9", "ED,00,4D keeps service", {7'd0, ieo}, 8'd0);
    fetch(8'hED);
    iei = 1'b0;
    fetch(8'h4D);
    iei = 1'b1; #1;
    chk("R10", "return with iei low ignored", {7'd0, ieo}, 8'd0);
  endtask

  task automatic t_release_across_read;
    fetch(8'hED);
    memread(8'h4D);
    chk("R7", "memory read not a fetch", {7'd0, ieo}, 8'd0);
    fetch(8'h4D);
    chk("R8", "ED,4D releases service", {7'd0, ieo}, 8'd1);
    chk("R1", "held request did not re-pend", {7'd0, int_n}, 8'd1);
  endtask

  task automatic t_rearm;
    irq_req = 1'b0;
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk);
    chk("R1", "new edge pends again", {7'd0, int_n}, 8'd0);
    ack_cycle("R4", 1'b1, 8'h3C);
    fetch(8'hED); fetch(8'hED); fetch(8'h4D);
    chk("R9", "ED,ED,4D releases service", {7'd0, ieo}, 8'd1);
    irq_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_load_vec();
    t_request();
    t_ack_lose();
    t_ack_win();
    t_bad_sequences();
    t_release_across_read();
    t_rearm();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule